// File: doc/BRIEF.md
# Sliding-Window Mean Estimator

This block keeps a running arithmetic mean of an unsigned sample stream over the most recent 2^WIN_LOG2 accepted samples. In the receiver it smooths the magnitude of a synchronization error. Two copies run side by side, one for the direct branch and one for the inverted branch. A downstream comparator subtracts one mean from the other to decide each data bit. The receiver builds it with WIN_LOG2 = 13, which gives a window of 8192 samples.

Each accepted sample is written into a circular buffer. The sample it overwrites, the one that has just left the window, is read out of the buffer. A sum register adds the new sample and removes the departing one. Until the buffer has wrapped once, the departing value reads as zero, so the sum needs no clearing logic. The mean is the sum shifted right by WIN_LOG2 bits. A flag reports when the window holds a full set of real samples.

Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `swm_mean`

## Requirements
- R1: While reset is held, and after it is released until a sample is accepted, `mean` is 0 and `valid` is 0.
- R2: A sample is accepted at a rising edge where `in_en` is 1. After the second rising edge from that edge, `mean` equals floor(S / 2^WIN_LOG2). S is the sum of the last 2^WIN_LOG2 accepted samples, up to and including that one.
- R3: A rising edge with `in_en` at 0 leaves `mean` and `valid` unchanged, whatever is on `in_data`.
- R4: `valid` stays 0 until the 2^WIN_LOG2-th accepted sample takes effect. It rises on the same edge that this sample updates `mean`, and it then stays 1 until reset.
- R5: Before the window has filled, the sample positions not yet written count as zero in S.
- R6: A window of full-scale samples (all ones) yields `mean` equal to the full-scale value, and the internal sum does not wrap.
- R7: The division truncates toward zero. A single sample v inside an otherwise zero window gives floor(v / 2^WIN_LOG2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_en | input | 1 | Sample qualifier; `in_data` is taken when 1 |
| in_data | input | DATA_W | Unsigned sample |
| mean | output | DATA_W | Mean of the current window |
| valid | output | 1 | High once the window has been filled by real samples |

## Verification
The bench builds the block with DATA_W = 8 and WIN_LOG2 = 4, a 16-word ring. With this setting every one of the 256 input codes can be applied as an isolated impulse, which sweeps the truncation of the division exhaustively. The ring also wraps hundreds of times within the run, so the pointer wrap and the zero-until-filled rule are exercised over and over. The stimulus includes a pre-fill ramp, a step up and a step down, and full-scale saturation. It also includes randomly gapped enables and a long run of random samples, all compared each cycle against a sum kept arithmetically in the bench.

// File: rtl/swm_pkg.sv
package swm_pkg;
  // Default sample width and log2 of the window length.
  // The receiver instantiates the block with a window exponent of 13.
  localparam int SWM_DATA_W   = 17;
  localparam int SWM_WIN_LOG2 = 11;
endpackage

// File: rtl/swm_ring.sv
// Circular delay buffer: returns, one cycle late, the word being overwritten.
// Reads as zero until the write pointer has wrapped once (R5).
module swm_ring #(
  parameter int W  = 17,
  parameter int AW = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic          wrap_q, wrap_d;
  logic [W-1:0]  rd_q, rd_d;

  always_comb begin
    wptr_d = wptr_q;
    wrap_d = wrap_q;
    rd_d   = rd_q;
    if (en) begin
      wptr_d = wptr_q + 1'b1;
      if (wptr_q == {AW{1'b1}}) wrap_d = 1'b1;
      rd_d = wrap_q ? mem[wptr_q] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      wrap_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      wrap_q <= wrap_d;
      rd_q   <= rd_d;
    end
  end

  // Storage array carries no reset; stale contents are masked by wrap_q.
  always_ff @(posedge clk) begin
    if (en) mem[wptr_q] <= din;
  end

  assign dout = rd_q;
endmodule

// File: rtl/swm_fill.sv
// Counts applied samples and raises a sticky full flag on the last slot (R4).
module swm_fill #(
  parameter int AW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic full
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (en && !full_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == {AW{1'b1}}) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign full = full_q;
endmodule

// File: rtl/swm_acc.sv
// Window sum: adds the entering sample, removes the leaving one (R2, R6).
module swm_acc #(
  parameter int W  = 17,
  parameter int AW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [W-1:0]    add,
  input  logic [W-1:0]    sub,
  output logic [W+AW-1:0] acc,
  output logic [W-1:0]    mean
);
  localparam int ACC_W = W + AW;

  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + {{AW{1'b0}}, add} - {{AW{1'b0}}, sub};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc  = acc_q;
  // Truncating division by the window length (R7).
  assign mean = acc_q[ACC_W-1:AW];
endmodule

// File: rtl/swm_mean.sv
module swm_mean
  import swm_pkg::*;
#(
  parameter int DATA_W   = SWM_DATA_W,
  parameter int WIN_LOG2 = SWM_WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] mean,
  output logic              valid
);
  localparam int ACC_W = DATA_W + WIN_LOG2;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // Stage 1: hold the entering sample while the ring read completes.
  logic              s1_en_q, s1_en_d;
  logic [DATA_W-1:0] s1_data_q, s1_data_d;

  always_comb begin
    s1_en_d   = in_en;
    s1_data_d = s1_data_q;
    if (in_en) s1_data_d = in_data;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      s1_en_q   <= 1'b0;
      s1_data_q <= '0;
    end else begin
      s1_en_q   <= s1_en_d;
      s1_data_q <= s1_data_d;
    end
  end

  logic [DATA_W-1:0] old_word;
  logic [ACC_W-1:0]  acc_sum;

  swm_ring #(.W(DATA_W), .AW(WIN_LOG2)) u_ring (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (in_en),
    .din   (in_data),
    .dout  (old_word)
  );

  swm_acc #(.W(DATA_W), .AW(WIN_LOG2)) u_acc (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (s1_en_q),
    .add   (s1_data_q),
    .sub   (old_word),
    .acc   (acc_sum),
    .mean  (mean)
  );

  swm_fill #(.AW(WIN_LOG2)) u_fill (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (s1_en_q),
    .full  (valid)
  );
endmodule

// File: rtl/swm_mean_chk.sv
module swm_mean_chk #(
  parameter int W  = 17,
  parameter int AW = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_en,
  input logic [W-1:0]    mean,
  input logic            valid,
  input logic [W+AW-1:0] acc
);
  localparam logic [W+AW-1:0] ACC_MAX = {{W{1'b1}}, {AW{1'b0}}};

  // R3: an idle edge leaves the mean untouched
  p_idle_mean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_en) |=> $stable(mean));

  // R3: an idle edge leaves the fill flag untouched
  p_idle_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_en) |=> $stable(valid));

  // R4: once set, the fill flag stays set
  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  // R4: the flag rises only as the result of an accepted sample
  p_valid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(in_en, 2));

  // R6: the window sum never exceeds a window of full-scale samples
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_MAX);
endmodule

bind swm_mean swm_mean_chk #(.W(DATA_W), .AW(WIN_LOG2)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .in_en (in_en),
  .mean  (mean),
  .valid (valid),
  .acc   (acc_sum)
);

// File: tb/sim_swm_mean.sv
module sim_swm_mean;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_en = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] mean;
  logic          valid;

  swm_mean #(.DATA_W(DW), .WIN_LOG2(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_data(in_data),
    .mean(mean), .valid(valid)
  );

  always #2 clk = ~clk;

  int    nchk = 0;
  int    nfail = 0;
  bit    run = 0;
  bit    done = 0;
  string cur_req = "R2";

  // Reference: window contents and count of accepted samples.
  int hist [DEPTH];
  int wp, nacc, st_mean, exp_mean;
  bit st_valid, exp_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] = 0;
      wp = 0; nacc = 0;
      st_mean = 0; st_valid = 0; exp_mean = 0; exp_valid = 0;
    end else begin
      exp_mean  = st_mean;
      exp_valid = st_valid;
      if (in_en) begin
        int s;
        hist[wp] = int'(in_data);
        wp = (wp + 1) % DEPTH;
        nacc++;
        s = 0;
        for (int i = 0; i < DEPTH; i++) s += hist[i];
        st_mean  = s / DEPTH;
        st_valid = (nacc >= DEPTH);
      end
    end
  end

  task automatic chk(string req, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk(cur_req, int'(mean), exp_mean);
      chk("R4", int'(valid), int'(exp_valid));
    end
  end

  task automatic drive(bit en, int d);
    @(negedge clk);
    in_en   = en;
    in_data = DW'(d);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: outputs quiet under reset and just after release
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(mean), 0);
      chk("R1", int'(valid), 0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1", int'(mean), 0);
      chk("R1", int'(valid), 0);
    end
    run = 1;

    // R5: constant level ramps in, unwritten slots count as zero
    cur_req = "R5";
    for (int i = 0; i < DEPTH + 4; i++) drive(1, 100);

    // R2: step up then step down
    cur_req = "R2";
    for (int i = 0; i < DEPTH + 4; i++) drive(1, 200);
    for (int i = 0; i < DEPTH + 4; i++) drive(1, 0);

    // R3: gapped enables, data toggling while idle
    cur_req = "R3";
    for (int i = 0; i < 80; i++) drive(bit'($urandom % 2), int'($urandom % 256));

    // R6: full-scale window
    cur_req = "R6";
    for (int i = 0; i < DEPTH + 4; i++) drive(1, 255);
    for (int i = 0; i < DEPTH; i++) drive(1, 0);

    // R7: every code as an isolated impulse, truncating division
    cur_req = "R7";
    for (int v = 0; v < 256; v++) begin
      drive(1, v);
      for (int k = 0; k < DEPTH; k++) drive(1, 0);
    end

    // R2: long random stream
    cur_req = "R2";
    for (int i = 0; i < 400; i++) drive(1, int'($urandom % 256));
    drive(0, 0);
    repeat (3) @(negedge clk);

    run  = 0;
    done = 1;
    finish_run();
  end
endmodule